// File: doc/BRIEF.md
# Doubleword Write Mask Bridge

This block connects a 64-bit single-beat processor write bus to a memory-controller port that can only enable whole 32-bit halves of each 64-bit transfer. Each bus beat carries eight byte-lane enables. The bridge turns them into a 2-bit half-word mask and passes the dword address and the data to memory one cycle later. A beat with no lanes enabled is dropped.

Some lane patterns cannot be expressed by the 2-bit mask. The bridge does not block such a write. It opens both mask bits, so the whole 64-bit doubleword receives the bus data exactly as it was driven. The bridge also logs the fault. It records the full byte address and a cause code, and raises an interrupt that stays asserted until software clears it.

As a result, a misaligned word store that the processor splits into beats damages more memory than it should. A store that crosses a doubleword boundary overwrites four words. A store that crosses only the word boundary inside one doubleword overwrites two words.

Top module: `wmb_bridge`

## Requirements
- R1: Byte-lane enables of exactly 8'h0F forward with mask 2'b01, and 8'hF0 forward with mask 2'b10. Neither raises an error. Lane i carries data bits [8i+7:8i]. Mask bit 0 covers lanes 0-3 and mask bit 1 covers lanes 4-7.
- R2: Enables of 8'hFF forward with mask 2'b11 and raise no error.
- R3: Enables of 8'h00 produce no memory write and no error.
- R4: Every other nonzero enable pattern forwards with mask 2'b11 and raises an error.
- R5: An accepted beat appears on the memory port one cycle later. The data is unmodified and the address is the bus address shifted right by 3.
- R6: The error cause is 1 when all enabled lanes lie in one half. It is 2 when enabled lanes lie in both halves.
- R7: The first error captures the full bus address into register offset 0. It also sets status register offset 1: bit 0 is pending, bit 1 is overflow and bits [3:2] hold the cause.
- R8: irq equals pending AND the enable bit (bit 0 of control offset 2). irq stays high until a write of 1 to offset 1 clears pending, overflow and cause.
- R9: An error that arrives while pending is set, with no clear in the same cycle, keeps the captured address and cause and sets overflow.
- R10: When a clear and a new error fall in the same cycle, the clear acts first. The new error is captured as a fresh one, with pending 1 and overflow 0.
- R11: A misaligned 32-bit store split into per-dword beats overwrites 4 words when it crosses a doubleword boundary, and 2 words when it crosses only the middle word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Write beat present |
| bus_addr | input | ADDR_W | Byte address of the beat |
| bus_be | input | LANES | Byte-lane enables |
| bus_data | input | 8*LANES | Write data |
| mem_valid | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-3 | Doubleword address |
| mem_data | output | 8*LANES | Data to memory |
| mem_mask | output | 2 | Half-word enables (bit 1 upper) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wbit | input | 1 | Written value of the single writable bit |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level error interrupt |

## Verification
An error beat and a software clear can fall in the same cycle. The bench provokes this by driving the clear write and a sub-word beat at the same clock edge while an earlier error is still pending. It then reads the status and address registers, which must show the new beat's address with cause 1, pending set and overflow clear. A second collision, a new error while pending with no clear, must instead keep the older address and set overflow.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_SUBWORD  = 2'd1,
    CAUSE_STRADDLE = 2'd2
  } cause_e;

  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
endpackage

// File: rtl/wmb_rst_sync.sv
module wmb_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_qn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_qn = sync_q[1];
endmodule

// File: rtl/wmb_classify.sv
module wmb_classify
  import wmb_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] be,
  output logic             drop,
  output logic             err,
  output logic [1:0]       mask,
  output cause_e           cause
);
  localparam int HALF = LANES / 2;

  logic [HALF-1:0] lo, hi;
  logic lo_any, hi_any, lo_full, hi_full, lo_ok, hi_ok;

  always_comb begin
    lo      = be[HALF-1:0];
    hi      = be[LANES-1:HALF];
    lo_any  = |lo;
    hi_any  = |hi;
    lo_full = &lo;
    hi_full = &hi;
    lo_ok   = lo_full || !lo_any;
    hi_ok   = hi_full || !hi_any;
    drop    = !lo_any && !hi_any;
    err     = !drop && !(lo_ok && hi_ok);
    if (drop)     mask = 2'b00;
    else if (err) mask = 2'b11;
    else          mask = {hi_any, lo_any};
    if (!err)                  cause = CAUSE_NONE;
    else if (lo_any && hi_any) cause = CAUSE_STRADDLE;
    else                       cause = CAUSE_SUBWORD;
  end

  // R1
  always_comb begin
    clean_half_chk: assert (err || !mask[0] || (be[HALF-1:0] == {HALF{1'b1}}))
      else $error("clean mask with partial lower half");
  end
endmodule

// File: rtl/wmb_fwd.sv
module wmb_fwd #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       take,
  input  logic [ADDR_W-1:0]          addr_in,
  input  logic [8*LANES-1:0]         data_in,
  input  logic [1:0]                 mask_in,
  output logic                       mem_valid,
  output logic [ADDR_W-$clog2(LANES)-1:0] mem_addr,
  output logic [8*LANES-1:0]         mem_data,
  output logic [1:0]                 mem_mask
);
  localparam int OFS_W = $clog2(LANES);
  localparam int DW_W  = ADDR_W - OFS_W;

  logic              valid_n;
  logic [DW_W-1:0]   addr_n;
  logic [8*LANES-1:0] data_n;
  logic [1:0]        mask_n;

  always_comb begin
    valid_n = take;
    addr_n  = mem_addr;
    data_n  = mem_data;
    mask_n  = mem_mask;
    if (take) begin
      addr_n = addr_in[ADDR_W-1:OFS_W];
      data_n = data_in;
      mask_n = mask_in;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_mask  <= 2'b00;
    end else begin
      mem_valid <= valid_n;
      mem_addr  <= addr_n;
      mem_data  <= data_n;
      mem_mask  <= mask_n;
    end
  end

  // R3
  strobe_has_mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_valid |-> (mem_mask != 2'b00));

  // R5
  data_passthru_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    take |=> (mem_valid && mem_data == $past(data_in)));
endmodule

// File: rtl/wmb_errlog.sv
module wmb_errlog
  import wmb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              err_evt,
  input  cause_e            cause_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wbit,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic              pend_q, ovf_q, en_q;
  cause_e            cause_q;
  logic [ADDR_W-1:0] addr_q;

  logic              pend_n, ovf_n, en_n, clr, cap;
  cause_e            cause_n;
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    clr     = reg_wr && (reg_addr == OFS_STAT) && reg_wbit;
    pend_n  = pend_q;
    ovf_n   = ovf_q;
    cause_n = cause_q;
    en_n    = en_q;
    if (reg_wr && reg_addr == OFS_CTRL) en_n = reg_wbit;
    if (clr) begin
      pend_n  = 1'b0;
      ovf_n   = 1'b0;
      cause_n = CAUSE_NONE;
    end
    cap = err_evt && !pend_n;
    if (err_evt && pend_n) ovf_n = 1'b1;
    if (cap) begin
      pend_n  = 1'b1;
      cause_n = cause_in;
    end
    addr_n = cap ? addr_in : addr_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
      en_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
      addr_q  <= '0;
    end else begin
      pend_q  <= pend_n;
      ovf_q   <= ovf_n;
      en_q    <= en_n;
      cause_q <= cause_n;
      addr_q  <= addr_n;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ADDR: reg_rdata = 32'(addr_q);
      OFS_STAT: reg_rdata = {28'd0, cause_q, ovf_q, pend_q};
      OFS_CTRL: reg_rdata = {31'd0, en_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  assign irq = pend_q && en_q;

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && err_evt && !clr) |=> ovf_q);

  // R9
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !clr) |=> ($stable(addr_q) && $stable(cause_q)));

  // R10
  fresh_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_evt && (!pend_q || clr)) |=> (pend_q && !ovf_q && addr_q == $past(addr_in)));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq && !clr && !(reg_wr && reg_addr == OFS_CTRL)) |=> irq);
endmodule

// File: rtl/wmb_bridge.sv
module wmb_bridge
  import wmb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [LANES-1:0]            bus_be,
  input  logic [8*LANES-1:0]          bus_data,
  output logic                        mem_valid,
  output logic [ADDR_W-$clog2(LANES)-1:0] mem_addr,
  output logic [8*LANES-1:0]          mem_data,
  output logic [1:0]                  mem_mask,
  input  logic                        reg_wr,
  input  logic [1:0]                  reg_addr,
  input  logic                        reg_wbit,
  output logic [31:0]                 reg_rdata,
  output logic                        irq
);
  logic   rst_qn, drop, err, take, err_evt;
  logic [1:0] mask;
  cause_e cause;

  wmb_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_qn (rst_qn)
  );

  wmb_classify #(.LANES(LANES)) u_cls (
    .be    (bus_be),
    .drop  (drop),
    .err   (err),
    .mask  (mask),
    .cause (cause)
  );

  assign take    = bus_valid && !drop;
  assign err_evt = bus_valid && err;

  wmb_fwd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fwd (
    .clk       (clk),
    .rst_ni    (rst_qn),
    .take      (take),
    .addr_in   (bus_addr),
    .data_in   (bus_data),
    .mask_in   (mask),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_mask  (mem_mask)
  );

  wmb_errlog #(.ADDR_W(ADDR_W)) u_log (
    .clk       (clk),
    .rst_ni    (rst_qn),
    .err_evt   (err_evt),
    .cause_in  (cause),
    .addr_in   (bus_addr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wbit  (reg_wbit),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // R4
  err_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_qn)
    (bus_valid && bus_be != 8'h00 && bus_be != 8'h0F && bus_be != 8'hF0 && bus_be != 8'hFF)
      |=> (mem_valid && mem_mask == 2'b11));

  // R1
  word_mask_chk: assert property (@(posedge clk) disable iff (!rst_qn)
    (bus_valid && bus_be == 8'h0F) |=> (mem_valid && mem_mask == 2'b01));
endmodule

// File: tb/wmb_bridge_test.sv
module wmb_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [7:0]  bus_be;
  logic [63:0] bus_data;
  logic        mem_valid;
  logic [28:0] mem_addr;
  logic [63:0] mem_data;
  logic [1:0]  mem_mask;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic        reg_wbit;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [31:0] memw [0:3];

  always #2.5 clk = ~clk;

  wmb_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_data(bus_data), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wbit(reg_wbit),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic b);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wbit = b;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // drive one beat; returns at the negedge after the capturing edge
  task automatic beat(input logic [31:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_be = be; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic apply_mem;
    if (mem_valid && mem_addr[28:1] == 28'd0) begin
      if (mem_mask[0]) memw[{mem_addr[0], 1'b0}] = mem_data[31:0];
      if (mem_mask[1]) memw[{mem_addr[0], 1'b1}] = mem_data[63:32];
    end
  endtask

  function automatic int changed;
    int n = 0;
    for (int i = 0; i < 4; i++) if (memw[i] != (32'hA5A5_0000 + i)) n++;
    return n;
  endfunction

  initial begin
    logic [31:0] v;
    bus_valid = 0; bus_addr = 0; bus_be = 0; bus_data = 0;
    reg_wr = 0; reg_addr = 0; reg_wbit = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(!mem_valid, "R3 reset mem_valid", 64'(mem_valid), 0);
    chk(!irq, "R8 reset irq", 64'(irq), 0);
    rd(2'd1, v);
    chk(v == 0, "R7 reset status", 64'(v), 0);

    wr(2'd2, 1'b1);
    rd(2'd2, v);
    chk(v == 1, "R8 enable readback", 64'(v), 1);

    // exhaustive enable sweep
    for (int b = 0; b < 256; b++) begin
      logic [7:0]  be;
      logic [31:0] a;
      logic [63:0] d;
      logic [1:0]  emask;
      logic        edrop, eerr;
      logic [1:0]  ecause;
      be = 8'(b);
      a  = 32'h4000_0000 + 32'(b * 24) + 32'(b % 8);
      d  = {8'(b), 8'(~b), 16'hC0DE, 8'(b * 3), 8'(b + 7), 16'h5A5A};
      edrop = (be == 8'h00);
      eerr  = !edrop && !(((be[3:0] == 4'hF) || (be[3:0] == 4'h0)) &&
                          ((be[7:4] == 4'hF) || (be[7:4] == 4'h0)));
      emask = edrop ? 2'b00 : (eerr ? 2'b11 : {be[7:4] != 0, be[3:0] != 0});
      ecause = !eerr ? 2'd0 : ((be[3:0] != 0 && be[7:4] != 0) ? 2'd2 : 2'd1);
      beat(a, be, d);
      if (edrop) begin
        chk(!mem_valid, "R3 drop", 64'(mem_valid), 0);
      end else begin
        chk(mem_valid && mem_mask == emask,
            (be == 8'hFF) ? "R2 full mask" : (eerr ? "R4 error mask" : "R1 word mask"),
            64'({mem_valid, mem_mask}), 64'({1'b1, emask}));
        chk(mem_data == d && mem_addr == a[31:3], "R5 data/address",
            mem_data ^ 64'(mem_addr), d ^ 64'(a[31:3]));
      end
      rd(2'd1, v);
      chk(v == {28'd0, ecause, 1'b0, eerr}, eerr ? "R6 cause" : "R3 no error",
          64'(v), 64'({28'd0, ecause, 1'b0, eerr}));
      chk(irq == eerr, "R8 irq level", 64'(irq), 64'(eerr));
      if (eerr) begin
        rd(2'd0, v);
        chk(v == a, "R7 address capture", 64'(v), 64'(a));
        wr(2'd1, 1'b1);
        chk(!irq, "R8 clear", 64'(irq), 0);
      end
    end

    // enable gating: error with interrupt disabled
    wr(2'd2, 1'b0);
    beat(32'h0000_1000, 8'h01, 64'h1);
    chk(!irq, "R8 gated irq", 64'(irq), 0);
    rd(2'd1, v);
    chk(v[0], "R8 pending without irq", 64'(v), 64'h5);
    wr(2'd2, 1'b1);
    chk(irq, "R8 enable raises irq", 64'(irq), 1);
    repeat (3) @(negedge clk);
    chk(irq, "R8 irq sticky", 64'(irq), 1);

    // overflow: second error while pending
    beat(32'h0000_2008, 8'h3C, 64'h2);
    rd(2'd1, v);
    chk(v == 32'h7, "R9 overflow keeps cause", 64'(v), 64'h7);
    rd(2'd0, v);
    chk(v == 32'h0000_1000, "R9 first address kept", 64'(v), 64'h1000);

    // clear and new error in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wbit = 1'b1;
    bus_valid = 1'b1; bus_addr = 32'h0000_3003; bus_be = 8'h08; bus_data = 64'h3;
    @(negedge clk);
    reg_wr = 1'b0; bus_valid = 1'b0;
    rd(2'd1, v);
    chk(v == 32'h5, "R10 fresh status", 64'(v), 64'h5);
    rd(2'd0, v);
    chk(v == 32'h0000_3003, "R10 fresh address", 64'(v), 64'h3003);
    wr(2'd1, 1'b1);

    // misaligned word store crossing a doubleword boundary (byte offset 7)
    for (int i = 0; i < 4; i++) memw[i] = 32'hA5A5_0000 + i;
    beat(32'h0000_0000, 8'h80, {2{32'hE02D_0043}});
    apply_mem;
    beat(32'h0000_0008, 8'h07, {2{32'hE02D_0043}});
    apply_mem;
    chk(changed() == 4, "R11 dword crossing", 64'(changed()), 4);
    wr(2'd1, 1'b1);

    // misaligned word store crossing only the word boundary (byte offset 3)
    for (int i = 0; i < 4; i++) memw[i] = 32'hA5A5_0000 + i;
    beat(32'h0000_0003, 8'h78, {2{32'h1122_3344}});
    apply_mem;
    chk(changed() == 2, "R11 word crossing", 64'(changed()), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule